// File: doc/BRIEF.md
# Last-Branch Record Ring Buffer

This block keeps a short history of taken control-flow transfers. Each retired branch event carries a source address, a target address, a branch kind, the privilege of the target and three qualifier flags (mispredicted, inside a transaction, transaction abort). Events that pass a suppress filter are written into a circular buffer of source/target word pairs. A top-of-stack pointer always indexes the newest record. The entry that lies i positions behind the newest one sits at index (tos - i) & (DEPTH - 1).

A select register chooses which branch classes are dropped and can switch on call-stack mode. In that mode calls push records and near returns pop the pointer, so the buffer follows the live call chain. A control register turns recording on. It can also arm a freeze, so that a performance interrupt stops capture until software disarms it. A single register port reads and writes every entry, the pointer, the select and control registers, and a wipe strobe. Software can therefore inspect a stack or restore a saved one.

Recording is run by a three-state machine. OFF does not record, RUN records and FROZEN holds the history. The transitions are:
- ENABLE: OFF to RUN when the enable bit is set.
- DISABLE: RUN to OFF when the enable bit is clear.
- FREEZE: RUN to FROZEN on an interrupt while freeze is armed and call-stack mode is off.
- THAW: FROZEN to RUN when the freeze bit is cleared and enable is set.
- THAW_OFF: FROZEN to OFF when the freeze bit is cleared and enable is clear.

The state follows the control register one clock after that register is written.

Top module: `lbr_ring`

## Requirements
- R1: After reset the pointer, every source and target entry, the select register and the control register all read zero.
- R2: In normal mode an accepted branch advances the pointer by one modulo DEPTH and writes the new record at the new pointer. The record i positions older than the newest is at (tos - i) & (DEPTH - 1).
- R3: A stored source word carries the mispredict flag in bit 63, the in-transaction flag in bit 62 and the abort flag in bit 61, with the source address zero-extended in the low bits. A stored target word is the target address zero-extended.
- R4: Select bit 0 drops branches whose target is ring 0, and select bit 1 drops branches whose target is any other ring. Select bit 2+k drops branch kind k. The kind codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch. Kind 7 is never recorded.
- R5: When select bit 9 is set (call-stack mode), kinds 1 and 2 push a record and kind 3 pops the pointer back by one modulo DEPTH without touching any entry. All other kinds are not recorded. The suppress bits still apply.
- R6: Control bit 0 enables recording and control bit 1 arms freeze-on-interrupt. Branches are captured only while recording is enabled and the buffer is not frozen, and a control write takes effect one clock after it is written.
- R7: With recording enabled, freeze armed and call-stack mode off, a pulse on the performance-interrupt input stops all capture. Capture resumes only after the freeze bit has been written to zero.
- R8: The performance interrupt has no effect when freeze is not armed, and it has no effect in call-stack mode.
- R9: Writing the wipe address zeroes every source and target entry and leaves the pointer unchanged.
- R10: The register port is addressed as follows. The top two address bits select the region: 0 for source entries, 1 for target entries, 2 for miscellaneous registers. The low index bits give the entry number. In region 2, index 0 is the pointer, 1 is the select register, 2 is the control register and 3 is the wipe strobe. Writes take effect at the clock edge and reads are combinational. The select register keeps 10 bits and the control register keeps 2 bits.
- R11: A branch event presented in a cycle in which the register port writes is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A retired taken branch is presented |
| br_from | input | VA_W | Branch source address |
| br_to | input | VA_W | Branch target address |
| br_kind | input | 3 | Branch kind code (see R4) |
| br_tgt_ring0 | input | 1 | Target runs at ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch was inside a transaction |
| br_abort | input | 1 | Branch was a transaction abort |
| pmi | input | 1 | Performance-monitoring interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | log2(DEPTH)+2 | Register address (see R10) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |

## Verification
The hardest cases to reach are the FROZEN state and a call-stack pop that wraps the pointer below entry zero. Both depend on an exact order of control writes, interrupt pulses and branch events. The bench drives a four-entry configuration through each of those orders: arming the freeze, pulsing the interrupt and then sending branches that must be dropped, and, in call-stack mode, sending more returns than calls. The filter is checked exhaustively: every suppress bit is swept against every kind and both target privileges, with the expected pointer and records computed arithmetically.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef enum logic [2:0] {
        BK_COND  = 3'd0,
        BK_RCALL = 3'd1,
        BK_ICALL = 3'd2,
        BK_NRET  = 3'd3,
        BK_IJMP  = 3'd4,
        BK_RJMP  = 3'd5,
        BK_FAR   = 3'd6,
        BK_RSVD  = 3'd7
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } rec_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } stack_act_e;

    localparam int SEL_W   = 10;
    localparam int CS_BIT  = 9;
    localparam int CTL_W   = 2;
    localparam int CTL_EN  = 0;
    localparam int CTL_FRZ = 1;
    localparam int WORD_W  = 64;

    localparam logic [1:0] RG_FROM = 2'd0;
    localparam logic [1:0] RG_TO   = 2'd1;
    localparam logic [1:0] RG_MISC = 2'd2;

    localparam logic [1:0] MISC_TOS  = 2'd0;
    localparam logic [1:0] MISC_SEL  = 2'd1;
    localparam logic [1:0] MISC_CTL  = 2'd2;
    localparam logic [1:0] MISC_WIPE = 2'd3;

endpackage

// File: rtl/lbr_filter.sv
module lbr_filter
    import lbr_pkg::*;
(
    input  br_kind_e            kind,
    input  logic                tgt_ring0,
    input  logic [SEL_W-1:0]    sel,
    output stack_act_e          act
);
    logic [3:0] kidx;
    logic       drop;

    always_comb begin
        kidx = 4'(kind) + 4'd2;
        drop = (tgt_ring0 ? sel[0] : sel[1]) || (kind == BK_RSVD);
        if (kind != BK_RSVD && sel[kidx])
            drop = 1'b1;
        act = ACT_NONE;
        if (!drop) begin
            if (sel[CS_BIT]) begin
                if (kind == BK_RCALL || kind == BK_ICALL)
                    act = ACT_PUSH;
                else if (kind == BK_NRET)
                    act = ACT_POP;
            end else begin
                act = ACT_PUSH;
            end
        end
    end
endmodule

// File: rtl/lbr_rec_fsm.sv
module lbr_rec_fsm
    import lbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       frz,
    input  logic       cs_mode,
    input  logic       pmi,
    output rec_state_e state,
    output logic       cap_ok
);
    rec_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en)
                    nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!en)
                    nxt = ST_OFF;
                else if (pmi && frz && !cs_mode)
                    nxt = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!frz)
                    nxt = en ? ST_RUN : ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        cap_ok = (state == ST_RUN);
    end
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] push_from,
    input  logic [WORD_W-1:0] push_to,
    input  logic              wipe,
    input  logic              tos_we,
    input  logic [IDX_W-1:0]  tos_wd,
    input  logic              from_we,
    input  logic              to_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_from,
    output logic [WORD_W-1:0] rd_to,
    output logic [IDX_W-1:0]  tos
);
    logic [WORD_W-1:0] from_q [DEPTH];
    logic [WORD_W-1:0] to_q   [DEPTH];
    logic [IDX_W-1:0]  tos_nxt;

    assign tos_nxt = tos + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            tos <= '0;
        else if (tos_we)
            tos <= tos_wd;
        else if (push)
            tos <= tos_nxt;
        else if (pop)
            tos <= tos - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n || wipe) begin
                from_q[g] <= '0;
                to_q[g]   <= '0;
            end else begin
                if (from_we && wr_idx == SLOT)
                    from_q[g] <= wr_data;
                else if (push && tos_nxt == SLOT)
                    from_q[g] <= push_from;
                if (to_we && wr_idx == SLOT)
                    to_q[g] <= wr_data;
                else if (push && tos_nxt == SLOT)
                    to_q[g] <= push_to;
            end
        end
    end

    assign rd_from = from_q[rd_idx];
    assign rd_to   = to_q[rd_idx];
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
    import lbr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int VA_W  = 48,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [VA_W-1:0]   br_from,
    input  logic [VA_W-1:0]   br_to,
    input  logic [2:0]        br_kind,
    input  logic              br_tgt_ring0,
    input  logic              br_mispred,
    input  logic              br_in_tx,
    input  logic              br_abort,
    input  logic              pmi,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    logic [1:0]        region;
    logic [IDX_W-1:0]  idx;
    logic              misc_we, from_we, to_we, tos_we, sel_we, ctl_we, wipe;
    logic [SEL_W-1:0]  sel_q;
    logic [CTL_W-1:0]  ctl_q;
    rec_state_e        state;
    logic              cap_ok, cap, push, pop;
    stack_act_e        act;
    logic [WORD_W-1:0] push_from, push_to, rd_from, rd_to;
    logic [IDX_W-1:0]  tos;

    assign region  = reg_addr[RA_W-1 -: 2];
    assign idx     = reg_addr[IDX_W-1:0];
    assign misc_we = reg_we && region == RG_MISC;
    assign from_we = reg_we && region == RG_FROM;
    assign to_we   = reg_we && region == RG_TO;
    assign tos_we  = misc_we && idx[1:0] == MISC_TOS;
    assign sel_we  = misc_we && idx[1:0] == MISC_SEL;
    assign ctl_we  = misc_we && idx[1:0] == MISC_CTL;
    assign wipe    = misc_we && idx[1:0] == MISC_WIPE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ctl_q <= '0;
        end else begin
            if (sel_we) sel_q <= reg_wdata[SEL_W-1:0];
            if (ctl_we) ctl_q <= reg_wdata[CTL_W-1:0];
        end
    end

    lbr_rec_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_q[CTL_EN]),
        .frz     (ctl_q[CTL_FRZ]),
        .cs_mode (sel_q[CS_BIT]),
        .pmi     (pmi),
        .state   (state),
        .cap_ok  (cap_ok)
    );

    lbr_filter u_filter (
        .kind      (br_kind_e'(br_kind)),
        .tgt_ring0 (br_tgt_ring0),
        .sel       (sel_q),
        .act       (act)
    );

    assign cap       = cap_ok && br_valid && !reg_we;
    assign push      = cap && act == ACT_PUSH;
    assign pop       = cap && act == ACT_POP;
    assign push_from = {br_mispred, br_in_tx, br_abort, 61'(br_from)};
    assign push_to   = WORD_W'(br_to);

    lbr_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_from (push_from),
        .push_to   (push_to),
        .wipe      (wipe),
        .tos_we    (tos_we),
        .tos_wd    (reg_wdata[IDX_W-1:0]),
        .from_we   (from_we),
        .to_we     (to_we),
        .wr_idx    (idx),
        .wr_data   (reg_wdata),
        .rd_idx    (idx),
        .rd_from   (rd_from),
        .rd_to     (rd_to),
        .tos       (tos)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RG_FROM: reg_rdata = rd_from;
            RG_TO:   reg_rdata = rd_to;
            RG_MISC: begin
                unique case (idx[1:0])
                    MISC_TOS: reg_rdata = WORD_W'(tos);
                    MISC_SEL: reg_rdata = WORD_W'(sel_q);
                    MISC_CTL: reg_rdata = WORD_W'(ctl_q);
                    default:  reg_rdata = '0;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk
    import lbr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [2:0]       br_kind,
    input logic             pmi,
    input logic             reg_we,
    input logic [SEL_W-1:0] sel_q,
    input logic [CTL_W-1:0] ctl_q,
    input rec_state_e       state,
    input logic [IDX_W-1:0] tos
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && state != ST_RUN) |=> $stable(tos)); // R6

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && br_valid && !reg_we && sel_q == '0 && br_kind != 3'd7)
        |=> tos == IDX_W'($past(tos) + 1'b1)); // R2

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && br_valid && !reg_we && sel_q == 10'h200 && br_kind == 3'd3)
        |=> tos == IDX_W'($past(tos) - 1'b1)); // R5

    AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && (!br_valid || br_kind == 3'd7)) |=> $stable(tos)); // R4

    AST_FREEZE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pmi && ctl_q == 2'b11 && !sel_q[CS_BIT])
        |=> state == ST_FROZEN); // R7

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && ctl_q[CTL_FRZ]) |=> state == ST_FROZEN); // R7

    AST_CS_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[CS_BIT] && state != ST_FROZEN) |=> state != ST_FROZEN); // R8
endmodule

bind lbr_ring lbr_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_valid (br_valid),
    .br_kind  (br_kind),
    .pmi      (pmi),
    .reg_we   (reg_we),
    .sel_q    (sel_q),
    .ctl_q    (ctl_q),
    .state    (state),
    .tos      (tos)
);

// File: tb/lbr_ring_test.sv
module lbr_ring_test;
    localparam int DEPTH = 4;
    localparam int VA_W  = 32;
    localparam int IDX_W = 2;
    localparam int RA_W  = 4;

    localparam logic [3:0] A_TOS  = 4'b1000;
    localparam logic [3:0] A_SEL  = 4'b1001;
    localparam logic [3:0] A_CTL  = 4'b1010;
    localparam logic [3:0] A_WIPE = 4'b1011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              br_valid = 1'b0;
    logic [VA_W-1:0]   br_from = '0, br_to = '0;
    logic [2:0]        br_kind = '0;
    logic              br_tgt_ring0 = 1'b0, br_mispred = 1'b0, br_in_tx = 1'b0, br_abort = 1'b0;
    logic              pmi = 1'b0;
    logic              reg_we = 1'b0;
    logic [RA_W-1:0]   reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] mfrom [DEPTH];
    logic [63:0] mto   [DEPTH];
    logic [1:0]  mtos;
    logic [9:0]  msel;
    logic [1:0]  mctl;
    bit          mfrz;

    always #2 clk = ~clk;

    lbr_ring #(.DEPTH(DEPTH), .VA_W(VA_W)) uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .br_kind(br_kind), .br_tgt_ring0(br_tgt_ring0), .br_mispred(br_mispred),
        .br_in_tx(br_in_tx), .br_abort(br_abort), .pmi(pmi), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == A_SEL) msel = d[9:0];
        if (a == A_CTL) begin
            mctl = d[1:0];
            if (!d[1]) mfrz = 1'b0;
        end
        if (a == A_TOS) mtos = d[1:0];
        if (a[3:2] == 2'b00) mfrom[a[1:0]] = d;
        if (a[3:2] == 2'b01) mto[a[1:0]] = d;
        if (a == A_WIPE)
            for (int i = 0; i < DEPTH; i++) begin mfrom[i] = '0; mto[i] = '0; end
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // expected action from the requirements: 0 none, 1 push, 2 pop
    function automatic int exp_act(input int k, input bit r0);
        bit drop;
        drop = r0 ? msel[0] : msel[1];
        if (k == 7) return 0;
        if (drop || msel[2 + k]) return 0;
        if (msel[9]) begin
            if (k == 1 || k == 2) return 1;
            if (k == 3) return 2;
            return 0;
        end
        return 1;
    endfunction

    task automatic send(input int k, input bit r0, input logic [31:0] f, input logic [31:0] t,
                        input bit mis, input bit itx, input bit ab);
        int a;
        @(negedge clk);
        br_valid = 1'b1; br_kind = 3'(k); br_tgt_ring0 = r0; br_from = f; br_to = t;
        br_mispred = mis; br_in_tx = itx; br_abort = ab;
        @(negedge clk);
        br_valid = 1'b0;
        a = exp_act(k, r0);
        if (mctl[0] && !mfrz) begin
            if (a == 1) begin
                mtos = mtos + 2'd1;
                mfrom[mtos] = {mis, itx, ab, 29'd0, f};
                mto[mtos] = {32'd0, t};
            end else if (a == 2) begin
                mtos = mtos - 2'd1;
            end
        end
    endtask

    task automatic pulse_pmi();
        @(negedge clk);
        pmi = 1'b1;
        @(negedge clk);
        pmi = 1'b0;
        if (mctl == 2'b11 && !msel[9]) mfrz = 1'b1;
    endtask

    task automatic check_tos(input string req);
        logic [63:0] d;
        rd(A_TOS, d);
        chk(req, d, {62'd0, mtos});
    endtask

    task automatic check_all(input string req);
        logic [63:0] d;
        check_tos(req);
        for (int i = 0; i < DEPTH; i++) begin
            logic [1:0] ix;
            ix = mtos - 2'(i);
            rd({2'b00, ix}, d);
            chk(req, d, mfrom[ix]);
            rd({2'b01, ix}, d);
            chk(req, d, mto[ix]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        for (int i = 0; i < DEPTH; i++) begin mfrom[i] = '0; mto[i] = '0; end
        mtos = '0; msel = '0; mctl = '0; mfrz = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1");
        rd(A_SEL, d); chk("R1 select", d, 64'd0);
        rd(A_CTL, d); chk("R1 control", d, 64'd0);

        // R6: disabled, nothing recorded
        send(0, 0, 32'h1000, 32'h2000, 0, 0, 0);
        check_tos("R6 disabled");

        // R2 R3: pushes with wrap and flag packing
        wr(A_CTL, 64'd1);
        for (int n = 0; n < 6; n++)
            send(n % 7, n[0], 32'hA000_0000 + n, 32'hB000_0000 + n, n[0], n[1], n[2]);
        check_all("R2 R3 push order");

        // R4: exhaustive suppress sweep
        for (int b = 0; b < 9; b++) begin
            wr(A_SEL, 64'(1) << b);
            for (int k = 0; k < 8; k++)
                for (int r = 0; r < 2; r++) begin
                    send(k, r[0], 32'h0100_0000 + (b << 8) + (k << 4) + r, 32'h0200_0000 + k, 1'b0, r[0], 1'b1);
                    check_tos("R4 suppress");
                end
            check_all("R4 entries");
        end
        wr(A_SEL, 64'd0);
        send(7, 0, 32'h77, 32'h78, 0, 0, 0);
        check_tos("R4 reserved kind");

        // R5: call-stack push/pop with pointer wrap
        wr(A_SEL, 64'h200);
        wr(A_TOS, 64'd1);
        send(1, 0, 32'hC1, 32'hD1, 0, 0, 0);
        send(2, 0, 32'hC2, 32'hD2, 1, 0, 0);
        send(0, 0, 32'hC3, 32'hD3, 0, 0, 0);
        send(5, 0, 32'hC4, 32'hD4, 0, 0, 0);
        check_all("R5 calls push");
        for (int n = 0; n < 4; n++) begin
            send(3, 0, 32'hE0 + n, 32'hF0, 0, 0, 0);
            check_tos("R5 return pops");
        end
        check_all("R5 pop keeps entries");
        wr(A_SEL, 64'h208);
        send(1, 0, 32'hC9, 32'hD9, 0, 0, 0);
        check_tos("R5 suppress applies");

        // R8: freeze armed but call-stack mode ignores interrupt
        wr(A_SEL, 64'h200);
        wr(A_CTL, 64'd3);
        pulse_pmi();
        send(1, 1, 32'h5151, 32'h6161, 0, 0, 0);
        check_all("R8 call-stack no freeze");

        // R8: interrupt with freeze off
        wr(A_SEL, 64'd0);
        wr(A_CTL, 64'd1);
        pulse_pmi();
        send(4, 0, 32'h5252, 32'h6262, 0, 1, 0);
        check_all("R8 no freeze when disarmed");

        // R7: freeze and thaw
        wr(A_CTL, 64'd3);
        pulse_pmi();
        send(0, 0, 32'h5353, 32'h6363, 0, 0, 0);
        send(6, 1, 32'h5454, 32'h6464, 0, 0, 0);
        check_all("R7 frozen drops");
        wr(A_CTL, 64'd3);
        send(0, 0, 32'h5555, 32'h6565, 0, 0, 0);
        check_tos("R7 still frozen");
        wr(A_CTL, 64'd1);
        send(0, 0, 32'h5656, 32'h6666, 1, 1, 1);
        check_all("R7 thaw resumes");

        // R11: write cycle drops branch
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_SEL; reg_wdata = 64'd0;
        br_valid = 1'b1; br_kind = 3'd0; br_from = 32'h9999; br_to = 32'h8888;
        @(negedge clk);
        reg_we = 1'b0; br_valid = 1'b0;
        check_all("R11 write blocks capture");

        // R10: direct register access
        wr(A_TOS, 64'd2);
        wr(4'b0001, 64'hDEAD_BEEF_0000_0001);
        wr(4'b0101, 64'h1234_5678_9ABC_DEF0);
        check_all("R10 direct write");
        wr(A_SEL, 64'hFFFF);
        rd(A_SEL, d); chk("R10 select width", d, 64'h3FF);
        wr(A_CTL, 64'hFC);
        rd(A_CTL, d); chk("R10 control width", d, 64'd0);

        // R9: wipe keeps pointer
        wr(A_WIPE, 64'd0);
        check_all("R9 wipe");

        // R6: disable again
        wr(A_SEL, 64'd0);
        send(0, 0, 32'h4242, 32'h4343, 0, 0, 0);
        check_all("R6 disabled after run");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule